// File: doc/BRIEF.md
# Write-to-Clear Interrupt Status Latch

This block keeps one status bit for each of eight interrupt sources and holds it until software acknowledges it. Six sources arrive as single-cycle event pulses that are already synchronous to the clock: a periodic tick, a tick watchdog, two timer underflows, a real-time-clock match and a serial-port modem-status change. Two sources are asynchronous pins. Each pin passes through a synchroniser, and a falling edge then sets its bit. On the battery pin, that falling edge counts only while the active-low external-power pin is high.

Software acknowledges a source by writing to its end-of-interrupt address. The write data is ignored. The tick and tick-watchdog bits share one acknowledge address, so a single write clears both. A separate address loads a per-source enable mask. The block drives the status bits and the mask out for read-back, along with one combined interrupt line that is high while any enabled bit is set.

Top module: `irq_eoi_latch`

## Requirements
- R1: After reset, `status`, `irq_en` and `irq` are all zero.
- R2: A one-cycle pulse on `tick_evt`, `wdog_evt`, `tmr1_uf`, `tmr2_uf`, `rtc_match` or `modem_chg` sets status bit 2, 3, 4, 5, 6 or 7 respectively at the next clock edge. Once set, the bit stays set until it is cleared.
- R3: A falling edge on `bat_ok_pin` while `ext_pwr_n_pin` is high sets status bit 0 on the third rising clock edge after the pin changes. A falling edge while `ext_pwr_n_pin` is low sets nothing. A change on `ext_pwr_n_pin` alone sets nothing.
- R4: A falling edge on `media_n_pin` sets status bit 1 on the third rising clock edge after the pin changes. A rising edge sets nothing.
- R5: A write of any data clears exactly one bit at these addresses: 0x600 clears bit 0, 0x640 clears bit 1, 0x6C0 clears bit 4, 0x700 clears bit 5, 0x740 clears bit 6 and 0x780 clears bit 7.
- R6: A single write to 0x680 clears status bits 2 and 3 together.
- R7: If a set event and the write that clears the same bit fall in the same cycle, the bit is set after that edge.
- R8: A write to any other address leaves the status bits unchanged. This includes addresses near the acknowledge addresses but not equal to them.
- R9: A write to 0x7C0 loads `wr_data` into `irq_en`, with bit i of the data enabling source i.
- R10: `irq` is high exactly when some status bit and its matching `irq_en` bit are both set. It follows combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bat_ok_pin | input | 1 | Asynchronous battery-good pin; falling edge raises bit 0 |
| ext_pwr_n_pin | input | 1 | Asynchronous active-low external-power pin; qualifies bit 0 |
| media_n_pin | input | 1 | Asynchronous media-change pin; falling edge raises bit 1 |
| tick_evt | input | 1 | Tick event pulse |
| wdog_evt | input | 1 | Tick watchdog event pulse |
| tmr1_uf | input | 1 | Timer 1 underflow pulse |
| tmr2_uf | input | 1 | Timer 2 underflow pulse |
| rtc_match | input | 1 | Real-time-clock match pulse |
| modem_chg | input | 1 | Modem status change pulse |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 12 | Bus write address offset |
| wr_data | input | 8 | Bus write data; used only for the mask load |
| status | output | 8 | Latched interrupt status bits |
| irq_en | output | 8 | Enable mask read-back |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench drives an event into a bit in the same cycle as the write that clears that bit. A design that gives priority to the clear would lose the interrupt. It writes to the shared tick address and expects two bits to drop; a decoder that maps each address to a single bit would leave the watchdog bit pending. It writes to an address four bytes off an acknowledge address and expects no change, which exposes a decoder that matches on partial address bits. On the pins, it checks that a battery edge with the qualifier low, a rising media edge and a lone qualifier change all set nothing. A detector that fires on either edge or ignores the qualifier would set the bit. Finally, it checks that a masked source keeps `irq` low while its status bit stays visible.

// File: rtl/irq_eoi_pkg.sv
package irq_eoi_pkg;
  localparam int NSRC  = 8;
  localparam int NSLOT = 8;          // 7 acknowledge slots + mask load slot
  localparam int MASK_SLOT = NSLOT - 1;

  // Map acknowledge-slot hits to the status bits they clear.
  // Slot 2 is shared by the tick and tick-watchdog bits.
  function automatic logic [NSRC-1:0] slot_clear(input logic [NSLOT-2:0] hit);
    logic [NSRC-1:0] clr;
    clr    = '0;
    clr[0] = hit[0];
    clr[1] = hit[1];
    clr[2] = hit[2];
    clr[3] = hit[2];
    for (int k = 3; k < NSLOT - 1; k++) clr[k+1] = hit[k];
    return clr;
  endfunction

  function automatic logic irq_any(input logic [NSRC-1:0] st, input logic [NSRC-1:0] en);
    return |(st & en);
  endfunction
endpackage

// File: rtl/pin_fall_detect.sv
module pin_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic qual_pin,
  output logic fall
);
  logic [STAGES-1:0] pin_sh;
  logic [STAGES-1:0] qual_sh;
  logic              pin_prev;
  logic              pin_cur;
  logic              qual_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sh   <= '1;
      qual_sh  <= '0;
      pin_prev <= 1'b1;
    end else begin
      pin_sh   <= {pin_sh[STAGES-2:0], pin};
      qual_sh  <= {qual_sh[STAGES-2:0], qual_pin};
      pin_prev <= pin_sh[STAGES-1];
    end
  end

  assign pin_cur  = pin_sh[STAGES-1];
  assign qual_cur = qual_sh[STAGES-1];
  assign fall     = pin_prev & ~pin_cur & qual_cur;

  // R3
  single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/eoi_decode.sv
module eoi_decode #(
  parameter int ADDR_W   = 12,
  parameter int BASE     = 'h600,
  parameter int STEP_LG2 = 6,
  parameter int NSLOT    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NSLOT-1:0]  slot_hit
);
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE + (k << STEP_LG2));
    assign slot_hit[k] = wr_en && (wr_addr == SLOT_ADDR);
  end

  // R8
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_hit));
endmodule

// File: rtl/irq_eoi_latch.sv
module irq_eoi_latch
  import irq_eoi_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int EOI_BASE    = 'h600,
  parameter int STEP_LG2    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bat_ok_pin,
  input  logic              ext_pwr_n_pin,
  input  logic              media_n_pin,
  input  logic              tick_evt,
  input  logic              wdog_evt,
  input  logic              tmr1_uf,
  input  logic              tmr2_uf,
  input  logic              rtc_match,
  input  logic              modem_chg,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NSRC-1:0]   wr_data,
  output logic [NSRC-1:0]   status,
  output logic [NSRC-1:0]   irq_en,
  output logic              irq
);
  logic            batt_fall;
  logic            media_fall;
  logic [NSLOT-1:0] slot_hit;
  logic [NSRC-1:0] set_evt;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] en_q;

  pin_fall_detect #(.STAGES(SYNC_STAGES)) i_batt (
    .clk(clk), .rst_n(rst_n), .pin(bat_ok_pin), .qual_pin(ext_pwr_n_pin), .fall(batt_fall));

  pin_fall_detect #(.STAGES(SYNC_STAGES)) i_media (
    .clk(clk), .rst_n(rst_n), .pin(media_n_pin), .qual_pin(1'b1), .fall(media_fall));

  eoi_decode #(.ADDR_W(ADDR_W), .BASE(EOI_BASE), .STEP_LG2(STEP_LG2), .NSLOT(NSLOT)) i_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .slot_hit(slot_hit));

  assign set_evt = {modem_chg, rtc_match, tmr2_uf, tmr1_uf, wdog_evt, tick_evt, media_fall, batt_fall};
  assign clr_vec = slot_clear(slot_hit[NSLOT-2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      en_q     <= '0;
    end else begin
      status_q <= (status_q & ~clr_vec) | set_evt;   // set wins over clear
      if (slot_hit[MASK_SLOT]) en_q <= wr_data;
    end
  end

  assign status = status_q;
  assign irq_en = en_q;
  assign irq    = irq_any(status_q, en_q);

  // R2
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((status & $past(set_evt)) == $past(set_evt)));
  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_evt) != '0) |=> ((status & $past(clr_vec & ~set_evt)) == '0));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0 && set_evt == '0) |=> $stable(status));
  // R10
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq);
endmodule

// File: tb/test_irq_eoi_latch.sv
module test_irq_eoi_latch;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bat_ok_pin = 1'b1, ext_pwr_n_pin = 1'b1, media_n_pin = 1'b1;
  logic tick_evt = 0, wdog_evt = 0, tmr1_uf = 0, tmr2_uf = 0, rtc_match = 0, modem_chg = 0;
  logic wr_en = 0;
  logic [11:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] status, irq_en;
  logic irq;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_eoi_latch i_irq_eoi_latch (
    .clk(clk), .rst_n(rst_n), .bat_ok_pin(bat_ok_pin), .ext_pwr_n_pin(ext_pwr_n_pin),
    .media_n_pin(media_n_pin), .tick_evt(tick_evt), .wdog_evt(wdog_evt), .tmr1_uf(tmr1_uf),
    .tmr2_uf(tmr2_uf), .rtc_match(rtc_match), .modem_chg(modem_chg), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .status(status), .irq_en(irq_en), .irq(irq));

  // {pulses[5:0] = modem,rtc,tmr2,tmr1,wdog,tick ; wr ; addr ; expected status}
  localparam logic [26:0] VEC [NV] = '{
    {6'b000001, 1'b0, 12'h000, 8'h04},  // R2 tick
    {6'b000010, 1'b0, 12'h000, 8'h0C},  // R2 watchdog
    {6'b000000, 1'b1, 12'h680, 8'h00},  // R6 shared clear
    {6'b111100, 1'b0, 12'h000, 8'hF0},  // R2 four at once
    {6'b000000, 1'b1, 12'h6C0, 8'hE0},  // R5 timer 1
    {6'b000000, 1'b1, 12'h700, 8'hC0},  // R5 timer 2
    {6'b001000, 1'b1, 12'h700, 8'hE0},  // R7 set beats clear
    {6'b000000, 1'b1, 12'h740, 8'hA0},  // R5 rtc
    {6'b000000, 1'b1, 12'h780, 8'h20},  // R5 modem
    {6'b000000, 1'b1, 12'h704, 8'h20},  // R8 near miss
    {6'b000000, 1'b1, 12'h700, 8'h00},  // R5 timer 2 again
    {6'b000001, 1'b1, 12'h600, 8'h04},  // R5 other clear leaves tick
    {6'b000000, 1'b1, 12'h680, 8'h00}   // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    chk("R1 status", status, 0);
    chk("R1 irq_en", irq_en, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1;
    idle(2);

    for (int i = 0; i < NV; i++) begin
      {modem_chg, rtc_match, tmr2_uf, tmr1_uf, wdog_evt, tick_evt} = VEC[i][26:21];
      wr_en = VEC[i][20]; wr_addr = VEC[i][19:8]; wr_data = 8'(8'h5A ^ i);
      @(posedge clk); @(negedge clk);
      {modem_chg, rtc_match, tmr2_uf, tmr1_uf, wdog_evt, tick_evt} = '0;
      wr_en = 0;
      chk($sformatf("R2/R5/R6/R7/R8 vec%0d", i), status, VEC[i][7:0]);
    end

    // R3 qualified battery edge
    bat_ok_pin = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R3 not yet", status, 0);
    @(negedge clk);
    chk("R3 set", status, 8'h01);
    wr(12'h600, 8'hFF);
    chk("R5 battery clear", status, 0);
    bat_ok_pin = 1; idle(4);
    ext_pwr_n_pin = 0; idle(4);
    bat_ok_pin = 0; idle(6);
    chk("R3 qualifier low", status, 0);
    ext_pwr_n_pin = 1; idle(6);
    chk("R3 qualifier alone", status, 0);
    bat_ok_pin = 1; idle(4);

    // R4 media edge
    media_n_pin = 0; idle(3);
    chk("R4 fall sets", status, 8'h02);
    wr(12'h640, 8'h00);
    chk("R5 media clear", status, 0);
    media_n_pin = 1; idle(6);
    chk("R4 rise ignored", status, 0);

    // R9 / R10 mask
    wr(12'h7C0, 8'h04);
    chk("R9 mask load", irq_en, 8'h04);
    chk("R8 mask write no status", status, 0);
    tmr1_uf = 1; @(posedge clk); @(negedge clk); tmr1_uf = 0;
    chk("R10 masked status", status, 8'h10);
    chk("R10 masked irq", irq, 0);
    tick_evt = 1; @(posedge clk); @(negedge clk); tick_evt = 0;
    chk("R10 enabled irq", irq, 1);
    wr(12'h680, 8'h33);
    chk("R10 irq drops", irq, 0);
    chk("R6 leaves timer1", status, 8'h10);
    wr(12'h7C0, 8'hFF);
    chk("R10 unmask", irq, 1);
    wr(12'h6C0, 8'h00);
    chk("R10 all clear", irq, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule